// File: doc/BRIEF.md
# Subtractive Frame Motion Detector

This block decides whether a scene has changed between two grayscale frames taken about half a second apart. It listens to the camera's frame-start pulses. On the first pulse it asks the frame store to capture that frame into the first analysis buffer, which uses the even byte lanes. It then lets a fixed number of further frames go by and asks for the next frame to go into the second buffer, which uses the odd byte lanes. Frames are interleaved in memory, so one 16-bit word holds the same pixel position from both frames.

Once the second capture has finished, which the next frame start marks, the block walks the shared analysis region one word at a time through a request/ready read port. For each word it forms the unsigned absolute difference of the two bytes and counts the positions whose difference is above a per-pixel threshold. At the end it compares that count with a second threshold, updates a motion flag and emits a one-cycle done pulse. It then waits for the next frame start to begin a new cycle.

The controller has five states:

- `ST_IDLE`: waits for a frame start. On one it issues the first capture request and moves to `ST_GAP`.
- `ST_GAP`: counts frame starts. The `GAP_FRAMES`-th one issues the second capture request and moves to `ST_FILL2`.
- `ST_FILL2`: the next frame start latches both thresholds and moves to `ST_SCAN`.
- `ST_SCAN`: reads word after word. The ready for the last word moves to `ST_DECIDE`.
- `ST_DECIDE`: publishes the verdict and returns to `ST_IDLE` unconditionally.

Top module: `frame_motion_detector`

## Requirements
- R1: After reset, `cap_req`, `rd_req`, `motion` and `done` are 0. In `ST_IDLE`, a frame start yields `cap_req` high for exactly one cycle, with `cap_sel` = 0 (first buffer, even lanes), in the cycle after the pulse is sampled.
- R2: After the first capture request, frame starts 1 to `GAP_FRAMES`-1 produce no capture request. Frame start number `GAP_FRAMES` yields a one-cycle `cap_req` with `cap_sel` = 1 (second buffer, odd lanes), and the gap counter returns to zero.
- R3: The frame start after the second capture request starts the scan. Frame starts that arrive during the scan cause no capture request and do not disturb the read sequence.
- R4: The scan issues exactly `NUM_PIX` reads, at addresses `BASE_ADDR`, `BASE_ADDR`+1, and so on up to `BASE_ADDR`+`NUM_PIX`-1, in ascending order. `rd_req` is never high with an address outside that range.
- R5: `rd_req` stays high with `rd_addr` unchanged until a one-cycle `rd_ready`. `rd_data` is taken in the `rd_ready` cycle, and the next address appears in the following cycle.
- R6: Bits [7:0] of a word are the earlier frame's pixel and bits [15:8] are the later frame's pixel. A position is counted when the unsigned absolute difference of the two is strictly greater than the pixel threshold, in either direction of change.
- R7: `motion` becomes 1 when the count is strictly greater than the count threshold, and 0 otherwise. `done` is high for exactly one cycle: the second cycle after the cycle of the final `rd_ready`. `motion` takes its new value in that same cycle.
- R8: `motion` changes only in a cycle where `done` is high, and holds its value through the following capture and scan.
- R9: `pix_thr` and `cnt_thr` are sampled once, when the scan starts. Changing them during a scan has no effect on that pass's verdict.
- R10: After `done`, the block is back in `ST_IDLE`. The next frame start begins a new cycle with the gap count starting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each camera frame start |
| pix_thr | input | PIX_W | Per-pixel absolute-difference threshold |
| cnt_thr | input | CNT_W | Differing-pixel count threshold |
| cap_req | output | 1 | One-cycle request to capture the current frame |
| cap_sel | output | 1 | Buffer select for `cap_req`: 0 = even lanes, 1 = odd lanes |
| rd_req | output | 1 | Read request, held until `rd_ready` |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_ready | input | 1 | One-cycle pulse: `rd_data` valid for the pending read |
| rd_data | input | 2*PIX_W | Word holding the earlier pixel in [7:0] and the later pixel in [15:8] |
| motion | output | 1 | Verdict of the most recent analysis |
| done | output | 1 | One-cycle pulse when `motion` is updated |

## Verification
The assertions assume that the memory side raises `rd_ready` only while `rd_req` is high, and only for a single cycle per request. They also assume that `frame_start` is a single-cycle pulse. The bench's memory responder waits for a visible request, checks the address, holds for one cycle and then pulses ready once. It drives frame starts as isolated one-cycle pulses with idle cycles between them, including one injected mid-scan, so the checked properties never see input behaviour outside these assumptions.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_FILL2,
        ST_SCAN,
        ST_DECIDE
    } fmd_state_e;

endpackage

// File: rtl/fmd_addr_walk.sv
module fmd_addr_walk #(
    parameter int NUM_PIX = 19200,
    parameter int IDX_W   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    assign last = (idx == IDX_W'(NUM_PIX - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step && !last) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/fmd_diff_count.sv
module fmd_diff_count #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample,
    input  logic [2*PIX_W-1:0] word,
    input  logic [PIX_W-1:0]   pix_thr,
    output logic [CNT_W-1:0]   count
);

    logic [PIX_W-1:0] early_px;
    logic [PIX_W-1:0] late_px;
    logic [PIX_W-1:0] delta;
    logic             hit;

    always_comb begin
        early_px = word[PIX_W-1:0];
        late_px  = word[2*PIX_W-1:PIX_W];
        if (late_px >= early_px) begin
            delta = late_px - early_px;
        end else begin
            delta = early_px - late_px;
        end
        hit = (delta > pix_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (sample && hit) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/frame_motion_detector.sv
module frame_motion_detector
    import fmd_pkg::*;
#(
    parameter int   ADDR_W     = 15,
    parameter int   PIX_W      = 8,
    parameter int   NUM_PIX    = 19200,
    parameter int   GAP_FRAMES = 15,
    parameter int   BASE_ADDR  = 0,
    localparam int  CNT_W      = $clog2(NUM_PIX + 1),
    localparam int  IDX_W      = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
    localparam int  GAP_W      = $clog2(GAP_FRAMES + 1),
    localparam int  WORD_W     = 2 * PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [PIX_W-1:0]  pix_thr,
    input  logic [CNT_W-1:0]  cnt_thr,
    output logic              cap_req,
    output logic              cap_sel,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [WORD_W-1:0] rd_data,
    output logic              motion,
    output logic              done
);

    fmd_state_e        state;
    fmd_state_e        state_nx;
    logic [GAP_W-1:0]  gap_cnt;
    logic [PIX_W-1:0]  pix_thr_q;
    logic [CNT_W-1:0]  cnt_thr_q;
    logic [IDX_W-1:0]  idx;
    logic              idx_last;
    logic [CNT_W-1:0]  diff_cnt;
    logic              gap_hit;
    logic              start_scan;
    logic              take_word;

    assign gap_hit    = (gap_cnt == GAP_W'(GAP_FRAMES - 1));
    assign start_scan = (state == ST_FILL2) && frame_start;
    assign take_word  = (state == ST_SCAN) && rd_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (frame_start)              state_nx = ST_GAP;
            ST_GAP:    if (frame_start && gap_hit)   state_nx = ST_FILL2;
            ST_FILL2:  if (frame_start)              state_nx = ST_SCAN;
            ST_SCAN:   if (rd_ready && idx_last)     state_nx = ST_DECIDE;
            ST_DECIDE:                               state_nx = ST_IDLE;
            default:                                 state_nx = ST_IDLE;
        endcase
    end

    // State register with the gap counter and the latched thresholds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            gap_cnt   <= '0;
            pix_thr_q <= '0;
            cnt_thr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                gap_cnt <= '0;
            end else if (state == ST_GAP && frame_start) begin
                gap_cnt <= gap_hit ? '0 : gap_cnt + 1'b1;
            end
            if (start_scan) begin
                pix_thr_q <= pix_thr;
                cnt_thr_q <= cnt_thr;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_req <= 1'b0;
            cap_sel <= 1'b0;
            done    <= 1'b0;
            motion  <= 1'b0;
        end else begin
            cap_req <= frame_start &&
                       ((state == ST_IDLE) || (state == ST_GAP && gap_hit));
            cap_sel <= (state == ST_GAP);
            done    <= (state == ST_DECIDE);
            if (state == ST_DECIDE) begin
                motion <= (diff_cnt > cnt_thr_q);
            end
        end
    end

    assign rd_req  = (state == ST_SCAN);
    assign rd_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(idx);

    fmd_addr_walk #(
        .NUM_PIX (NUM_PIX),
        .IDX_W   (IDX_W)
    ) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_scan),
        .step  (take_word),
        .idx   (idx),
        .last  (idx_last)
    );

    fmd_diff_count #(
        .PIX_W (PIX_W),
        .CNT_W (CNT_W)
    ) u_diff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_scan),
        .sample  (take_word),
        .word    (rd_data),
        .pix_thr (pix_thr_q),
        .count   (diff_cnt)
    );

endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
    parameter int ADDR_W    = 15,
    parameter int NUM_PIX   = 19200,
    parameter int BASE_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_req,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ready,
    input logic              motion,
    input logic              done
);

    assert_cap_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |=> !cap_req);

    assert_no_cap_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |-> !rd_req);

    assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr >= ADDR_W'(BASE_ADDR)) &&
                   (rd_addr <= ADDR_W'(BASE_ADDR + NUM_PIX - 1)));

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    assert_motion_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(motion));

endmodule

bind frame_motion_detector fmd_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_PIX   (NUM_PIX),
    .BASE_ADDR (BASE_ADDR)
) u_fmd_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_req  (cap_req),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .motion   (motion),
    .done     (done)
);

// File: tb/tb_frame_motion_detector.sv
module tb_frame_motion_detector;

    localparam int ADDR_W = 15;
    localparam int PIX_W  = 8;
    localparam int NPIX   = 8;
    localparam int GAP    = 3;
    localparam int BASE   = 100;
    localparam int CW     = $clog2(NPIX + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [PIX_W-1:0]  pix_thr = '0;
    logic [CW-1:0]     cnt_thr = '0;
    logic              cap_req;
    logic              cap_sel;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ready = 1'b0;
    logic [15:0]       rd_data = '0;
    logic              motion;
    logic              done;

    logic [15:0]       mem_img [NPIX];
    int                checks = 0;
    int                fails = 0;
    logic              prev_motion = 1'b0;

    always #10 clk = ~clk;

    frame_motion_detector #(
        .ADDR_W     (ADDR_W),
        .PIX_W      (PIX_W),
        .NUM_PIX    (NPIX),
        .GAP_FRAMES (GAP),
        .BASE_ADDR  (BASE)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_thr     (pix_thr),
        .cnt_thr     (cnt_thr),
        .cap_req     (cap_req),
        .cap_sel     (cap_sel),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .motion      (motion),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit ref_motion(input int pthr, input int cthr);
        int n = 0;
        for (int i = 0; i < NPIX; i++) begin
            int e = int'(mem_img[i][7:0]);
            int l = int'(mem_img[i][15:8]);
            int d = (l > e) ? l - e : e - l;
            if (d > pthr) n++;
        end
        return n > cthr;
    endfunction

    task automatic frame_pulse(output logic req, output logic sel);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        req = cap_req;
        sel = cap_sel;
        @(negedge clk);
        check(cap_req == 1'b0, "R1", "cap_req width", int'(cap_req), 0);
        repeat (2) @(negedge clk);
    endtask

    // One full capture/scan cycle with a responding memory model
    task automatic run_pass(input int pthr, input int cthr, input bit inject);
        logic r, s;
        bit   exp_m;
        exp_m   = ref_motion(pthr, cthr);
        pix_thr = PIX_W'(pthr);
        cnt_thr = CW'(cthr);
        frame_pulse(r, s);
        check(r == 1'b1 && s == 1'b0, "R1", "first capture req/sel", {r, s}, 2);
        for (int g = 1; g < GAP; g++) begin
            frame_pulse(r, s);
            check(r == 1'b0, "R2", "capture during gap", int'(r), 0);
        end
        frame_pulse(r, s);
        check(r == 1'b1 && s == 1'b1, "R2", "second capture req/sel", {r, s}, 3);
        check(motion == prev_motion, "R8", "motion held", int'(motion), int'(prev_motion));
        frame_pulse(r, s);
        check(r == 1'b0, "R3", "no capture at scan start", int'(r), 0);
        for (int i = 0; i < NPIX; i++) begin
            for (int k = 0; k < 20; k++) begin
                if (rd_req) break;
                @(negedge clk);
            end
            check(rd_req == 1'b1, "R4", "read request present", int'(rd_req), 1);
            check(rd_addr == ADDR_W'(BASE + i), "R4", "read address", int'(rd_addr), BASE + i);
            @(negedge clk);
            check(rd_req == 1'b1 && rd_addr == ADDR_W'(BASE + i), "R5",
                  "request held while waiting", int'(rd_addr), BASE + i);
            if (inject && i == 1) begin
                frame_start = 1'b1;
                pix_thr = 8'hFF;
                cnt_thr = CW'(NPIX);
            end
            rd_ready = 1'b1;
            rd_data  = mem_img[i];
            @(negedge clk);
            rd_ready = 1'b0;
            rd_data  = 16'hDEAD;
            frame_start = 1'b0;
            if (inject && i == 1) begin
                @(negedge clk);
                check(cap_req == 1'b0, "R3", "frame start during scan ignored", int'(cap_req), 0);
            end
        end
        check(rd_req == 1'b0 && done == 1'b0, "R4", "no read after last word",
              int'(rd_req), 0);
        @(negedge clk);
        check(done == 1'b1, "R7", "done pulse", int'(done), 1);
        check(motion == exp_m, inject ? "R9" : "R7", "motion verdict", int'(motion), int'(exp_m));
        @(negedge clk);
        check(done == 1'b0, "R7", "done single cycle", int'(done), 0);
        check(motion == exp_m, "R8", "motion after done", int'(motion), int'(exp_m));
        prev_motion = exp_m;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        check(cap_req == 0 && rd_req == 0 && motion == 0 && done == 0, "R1",
              "reset outputs", {cap_req, rd_req, motion, done}, 0);
    endtask

    task automatic test_still_scene();
        for (int i = 0; i < NPIX; i++) mem_img[i] = {8'(16 * i), 8'(16 * i)};
        run_pass(5, 0, 1'b0);
    endtask

    task automatic test_moving_scene();
        // R6: rises, falls and a full-scale 0xFF to 0x00 swing all count
        mem_img[0] = {8'd80,  8'd50};
        mem_img[1] = {8'd50,  8'd80};
        mem_img[2] = {8'h00,  8'hFF};
        mem_img[3] = {8'hFF,  8'h00};
        mem_img[4] = {8'd200, 8'd170};
        mem_img[5] = {8'd12,  8'd42};
        mem_img[6] = {8'd100, 8'd102};
        mem_img[7] = {8'd33,  8'd31};
        run_pass(10, 5, 1'b0);
    endtask

    task automatic test_threshold_edges();
        // R6: delta equal to threshold not counted; R7: count equal to threshold is no motion
        for (int i = 0; i < NPIX; i++)
            mem_img[i] = (i < 3) ? {8'd61, 8'd50} : {8'd40, 8'd50};
        run_pass(10, 3, 1'b0);
    endtask

    task automatic test_sampled_thresholds();
        // R9 with R3: thresholds change and a frame start arrives mid-scan
        for (int i = 0; i < NPIX; i++)
            mem_img[i] = (i < 3) ? {8'd20, 8'd45} : {8'd90, 8'd90};
        run_pass(20, 2, 1'b1);
    endtask

    task automatic test_new_cycle();
        // R10: a fresh cycle after done restarts the gap count from zero
        for (int i = 0; i < NPIX; i++) mem_img[i] = {8'd7, 8'd7};
        run_pass(0, 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_still_scene();
        test_moving_scene();
        test_threshold_edges();
        test_sampled_thresholds();
        test_new_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule